// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block makes the coherence decision for one access to a snooping write-back cache that keeps each line in one of four states: Modified, Exclusive, Shared or Invalid. The surrounding cache has already done the tag lookup and picked a replacement way. It hands the controller one request: a command, a hit flag, the current state of the addressed line, and on a miss the state and line address of the victim. The controller then runs the whole protocol sequence for that request.

The sequence has up to five steps, always in the same order. The first is the snoop response, for snoop commands only. Next comes a write-back on the system bus, then the invalidate messages to the upper-level cache, then the fill or upgrade operation on the bus. The last step is a completion pulse. That pulse carries the new line state, an error flag for protocol-illegal combinations, and an LRU-invalidate event. Bus operations go out one at a time over a valid/ready handshake. The snoop result that other caches return with a bus read decides whether a filled line becomes Shared or Exclusive.

A line is `LINE_BYTES` long and the upper-level cache uses `UL_LINE_BYTES` lines. Each upper-level invalidation therefore goes out as several consecutive messages, one for each upper-level line.

Top module: `mesi_coh_ctrl`

## Requirements
- R1: While reset is held and right after its release, the controller is idle: `req_ready` is 1 and `bus_valid`, `ul_inv_valid`, `snp_resp_valid`, `done` are 0.
- R2: A CPU read (cmd 0) that misses, or that hits a line in I (state 0), issues bus READ (op 0) for the request line. The line ends in S (1) if the returned snoop result is HIT (1) or HITM (2), and in E (2) if the result is NOHIT (0).
- R3: A CPU write (cmd 1) to a missing or I line issues bus RWIM (op 3). A write hit in S issues bus INVALIDATE (op 2). A write hit in E issues no bus operation. All of these end in M (3). A CPU read hit in M, E or S issues no bus operation and keeps the state.
- R4: On a CPU miss whose victim is in M, the controller first issues bus WRITE (op 1) of the victim line, then sends the upper-level invalidation of the victim line, and only then issues the READ or RWIM fill.
- R5: A snoop read (cmd 2) that hits M responds HITM, issues bus WRITE of the line and ends in S. One that hits E or S responds HIT and ends in S. A snoop write (cmd 3) that hits S responds HIT and keeps S.
- R6: A snoop RWIM (cmd 5) that hits M responds HITM, issues bus WRITE and ends in I. A snoop RWIM that hits E or S, and a snoop invalidate (cmd 4) that hits S, respond HIT and end in I. Every such move to I sends an upper-level invalidation of the line and raises `lru_inv` with `done`.
- R7: A snoop that misses, or that hits a line in I, responds NOHIT. It issues no bus operation and no upper-level message, and the completion state equals the `req_state` that was presented.
- R8: An upper-level invalidation is `LINE_BYTES/UL_LINE_BYTES` messages on consecutive cycles. Message k carries the byte address of the line plus k*`UL_LINE_BYTES`, which by default is offset 0x00 and then 0x20.
- R9: A snoop write or snoop invalidate that hits M or E, and the reserved command codes 6 and 7, leave the state unchanged and set `done_err` with `done`. The illegal snoops still respond NOHIT.
- R10: `bus_valid` stays high with stable `bus_op` and `bus_line` until `bus_ready`. `bus_snoop_res` is sampled only in the handshake cycle.
- R11: The response pulse comes in the cycle after acceptance. At most one of response, bus request, upper-level message and completion is active in any cycle. `done` is the last event, and `req_ready` returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_cmd | input | 3 | Command code (0 CPU read, 1 CPU write, 2 snoop read, 3 snoop write, 4 snoop invalidate, 5 snoop RWIM) |
| req_hit | input | 1 | Tag matched in the set |
| req_state | input | 2 | State of the matching line (0 I, 1 S, 2 E, 3 M) |
| req_victim_state | input | 2 | State of the chosen victim on a miss |
| req_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the request |
| req_victim_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the victim |
| bus_valid | output | 1 | Bus operation requested |
| bus_ready | input | 1 | Bus operation completes this cycle |
| bus_op | output | 2 | 0 READ, 1 WRITE, 2 INVALIDATE, 3 RWIM |
| bus_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the bus operation |
| bus_snoop_res | input | 2 | Result from other caches (0 NOHIT, 1 HIT, 2 HITM) |
| snp_resp_valid | output | 1 | Snoop response pulse |
| snp_resp | output | 2 | Snoop response code |
| ul_inv_valid | output | 1 | Upper-level invalidate message |
| ul_inv_addr | output | ADDR_W | Byte address of the upper-level line |
| done | output | 1 | Request complete |
| done_state | output | 2 | Final line state |
| done_err | output | 1 | Protocol-illegal combination |
| lru_inv | output | 1 | Line left for I due to a snoop |

## Verification
Read traffic goes to line addresses whose low bits produce each of the three snoop results. This separates the Shared fill from the Exclusive fill, and it tells a hit on an Invalid line apart from a true miss. Write traffic sweeps every starting state to show which bus operation, if any, each one triggers. Misses with Modified and non-Modified victims show that the write-back and the split upper-level messages come before the fill and only when they are needed. Snoops cover every command against every state, including misses and the illegal pairs. Each expected response, bus operation, message address and completion word is compared in order, while the bus ready delay varies from zero to two cycles.

// File: rtl/mesi_coh_pkg.sv
`timescale 1ns/1ps
package mesi_coh_pkg;

  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_e;

  typedef enum logic [2:0] {
    CMD_CPU_RD   = 3'd0,
    CMD_CPU_WR   = 3'd1,
    CMD_SNP_RD   = 3'd2,
    CMD_SNP_WR   = 3'd3,
    CMD_SNP_INV  = 3'd4,
    CMD_SNP_RWIM = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {BOP_READ = 2'd0, BOP_WRITE = 2'd1, BOP_INVAL = 2'd2, BOP_RWIM = 2'd3} bus_op_e;

  typedef enum logic [1:0] {SR_NOHIT = 2'd0, SR_HIT = 2'd1, SR_HITM = 2'd2} snp_res_e;

  // Step order matters: the sequencer walks phases in ascending value.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RESP = 3'd1,
    PH_WB   = 3'd2,
    PH_UL   = 3'd3,
    PH_FILL = 3'd4,
    PH_DONE = 3'd5
  } phase_e;

  typedef struct packed {
    logic       resp_en;
    logic [1:0] resp;
    logic       wb_en;
    logic       wb_victim;
    logic       ul_en;
    logic       ul_victim;
    logic       fill_en;
    logic [1:0] fill_op;
    logic       use_result;
    logic [1:0] final_st;
    logic       lru_inv;
    logic       illegal;
  } plan_t;

  // Decide the whole protocol sequence for one request.
  function automatic plan_t plan_access(input logic [2:0] cmd, input logic hit,
                                        input logic [1:0] st, input logic [1:0] vst);
    plan_t p;
    logic  present;
    logic  is_snoop;
    present  = hit && (st != LS_I);
    is_snoop = (cmd >= CMD_SNP_RD) && (cmd <= CMD_SNP_RWIM);
    p          = '0;
    p.final_st = st;
    p.resp     = SR_NOHIT;
    p.resp_en  = is_snoop;
    case (cmd)
      CMD_CPU_RD: if (!present) begin
        p.fill_en    = 1'b1;
        p.fill_op    = BOP_READ;
        p.use_result = 1'b1;
      end
      CMD_CPU_WR: begin
        p.final_st = LS_M;
        if (!present) begin
          p.fill_en = 1'b1;
          p.fill_op = BOP_RWIM;
        end else if (st == LS_S) begin
          p.fill_en = 1'b1;
          p.fill_op = BOP_INVAL;
        end
      end
      CMD_SNP_RD: if (present) begin
        p.final_st = LS_S;
        p.resp     = (st == LS_M) ? SR_HITM : SR_HIT;
        p.wb_en    = (st == LS_M);
      end
      CMD_SNP_WR: if (present) begin
        if (st == LS_S) p.resp = SR_HIT;
        else p.illegal = 1'b1;
      end
      CMD_SNP_INV: if (present) begin
        if (st == LS_S) begin
          p.resp     = SR_HIT;
          p.final_st = LS_I;
          p.ul_en    = 1'b1;
          p.lru_inv  = 1'b1;
        end else begin
          p.illegal = 1'b1;
        end
      end
      CMD_SNP_RWIM: if (present) begin
        p.resp     = (st == LS_M) ? SR_HITM : SR_HIT;
        p.wb_en    = (st == LS_M);
        p.final_st = LS_I;
        p.ul_en    = 1'b1;
        p.lru_inv  = 1'b1;
      end
      default: p.illegal = 1'b1;
    endcase
    if ((cmd == CMD_CPU_RD || cmd == CMD_CPU_WR) && !hit && vst == LS_M) begin
      p.wb_en     = 1'b1;
      p.wb_victim = 1'b1;
      p.ul_en     = 1'b1;
      p.ul_victim = 1'b1;
    end
    return p;
  endfunction

  // Fill state from the result returned with a bus read.
  function automatic logic [1:0] fill_state(input logic [1:0] res);
    return (res == SR_NOHIT) ? LS_E : LS_S;
  endfunction

  // Next phase after cur; steps = {fill, ul, wb, resp}.
  function automatic phase_e step_after(input phase_e cur, input logic [3:0] steps);
    if (cur < PH_RESP && steps[0]) return PH_RESP;
    if (cur < PH_WB   && steps[1]) return PH_WB;
    if (cur < PH_UL   && steps[2]) return PH_UL;
    if (cur < PH_FILL && steps[3]) return PH_FILL;
    return PH_DONE;
  endfunction

endpackage

// File: rtl/mesi_coh_seq.sv
`timescale 1ns/1ps
module mesi_coh_seq
  import mesi_coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] steps_now,
  input  logic [3:0] steps_held,
  input  logic       bus_hs,
  input  logic       ul_last,
  output phase_e     phase
);

  phase_e phase_d;

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_IDLE: if (start)   phase_d = step_after(PH_IDLE, steps_now);
      PH_RESP:              phase_d = step_after(PH_RESP, steps_held);
      PH_WB:   if (bus_hs)  phase_d = step_after(PH_WB, steps_held);
      PH_UL:   if (ul_last) phase_d = step_after(PH_UL, steps_held);
      PH_FILL: if (bus_hs)  phase_d = PH_DONE;
      PH_DONE:              phase_d = PH_IDLE;
      default:              phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  AST_RESP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RESP) |-> $past(phase) == PH_IDLE); // R11

endmodule

// File: rtl/mesi_coh_ul_split.sv
`timescale 1ns/1ps
module mesi_coh_ul_split #(
  parameter int LINE_AW = 26,
  parameter int OFF_W   = 6,
  parameter int UL_MSGS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  logic [LINE_AW-1:0]       line,
  output logic                     ul_valid,
  output logic [LINE_AW+OFF_W-1:0] ul_addr,
  output logic                     ul_last
);

  localparam int CNT_W = (UL_MSGS > 1) ? $clog2(UL_MSGS) : 1;
  localparam int PIECE = (1 << OFF_W) / UL_MSGS;
  localparam int AW    = LINE_AW + OFF_W;

  function automatic logic [OFF_W-1:0] piece_offset(input logic [CNT_W-1:0] k);
    return OFF_W'(k) * OFF_W'(PIECE);
  endfunction

  logic [CNT_W-1:0] cnt;

  assign ul_valid = active;
  assign ul_last  = active && (cnt == CNT_W'(UL_MSGS - 1));
  assign ul_addr  = {line, piece_offset(cnt)};

  always_ff @(posedge clk) begin
    if (!rst_n || !active || ul_last) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  AST_UL_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ul_valid && !ul_last |=> ul_valid && (ul_addr == $past(ul_addr) + AW'(PIECE))); // R8

endmodule

// File: rtl/mesi_coh_ctrl.sv
`timescale 1ns/1ps
module mesi_coh_ctrl
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 64,
  parameter int UL_LINE_BYTES = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [2:0]                            req_cmd,
  input  logic                                  req_hit,
  input  logic [1:0]                            req_state,
  input  logic [1:0]                            req_victim_state,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  req_line,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  req_victim_line,
  output logic                                  bus_valid,
  input  logic                                  bus_ready,
  output logic [1:0]                            bus_op,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  bus_line,
  input  logic [1:0]                            bus_snoop_res,
  output logic                                  snp_resp_valid,
  output logic [1:0]                            snp_resp,
  output logic                                  ul_inv_valid,
  output logic [ADDR_W-1:0]                     ul_inv_addr,
  output logic                                  done,
  output logic [1:0]                            done_state,
  output logic                                  done_err,
  output logic                                  lru_inv
);

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int LINE_AW = ADDR_W - OFF_W;
  localparam int UL_MSGS = LINE_BYTES / UL_LINE_BYTES;

  plan_t              plan_d;
  plan_t              plan_q;
  logic [LINE_AW-1:0] line_q;
  logic [LINE_AW-1:0] victim_q;
  phase_e             phase;
  logic               accept;
  logic               bus_hs;
  logic               ul_last;
  logic [3:0]         steps_now;
  logic [3:0]         steps_held;

  assign plan_d     = plan_access(req_cmd, req_hit, req_state, req_victim_state);
  assign steps_now  = {plan_d.fill_en, plan_d.ul_en, plan_d.wb_en, plan_d.resp_en};
  assign steps_held = {plan_q.fill_en, plan_q.ul_en, plan_q.wb_en, plan_q.resp_en};

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign bus_hs    = bus_valid && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plan_q   <= '0;
      line_q   <= '0;
      victim_q <= '0;
    end else if (accept) begin
      plan_q   <= plan_d;
      line_q   <= req_line;
      victim_q <= req_victim_line;
    end else if (phase == PH_FILL && bus_hs && plan_q.use_result) begin
      plan_q.final_st <= fill_state(bus_snoop_res);
    end
  end

  mesi_coh_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .steps_now  (steps_now),
    .steps_held (steps_held),
    .bus_hs     (bus_hs),
    .ul_last    (ul_last),
    .phase      (phase)
  );

  mesi_coh_ul_split #(
    .LINE_AW (LINE_AW),
    .OFF_W   (OFF_W),
    .UL_MSGS (UL_MSGS)
  ) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (phase == PH_UL),
    .line     (plan_q.ul_victim ? victim_q : line_q),
    .ul_valid (ul_inv_valid),
    .ul_addr  (ul_inv_addr),
    .ul_last  (ul_last)
  );

  assign snp_resp_valid = (phase == PH_RESP);
  assign snp_resp       = plan_q.resp;

  assign bus_valid = (phase == PH_WB) || (phase == PH_FILL);
  assign bus_op    = (phase == PH_WB) ? BOP_WRITE : plan_q.fill_op;
  assign bus_line  = (phase == PH_WB && plan_q.wb_victim) ? victim_q : line_q;

  assign done       = (phase == PH_DONE);
  assign done_state = plan_q.final_st;
  assign done_err   = done && plan_q.illegal;
  assign lru_inv    = done && plan_q.lru_inv;

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_op) && $stable(bus_line)); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_valid, ul_inv_valid, snp_resp_valid, done})); // R11
  AST_HITM_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp_valid && snp_resp == SR_HITM |=> bus_valid && bus_op == BOP_WRITE); // R5
  AST_LRU_TO_I: assert property (@(posedge clk) disable iff (!rst_n)
    lru_inv |-> done && done_state == LS_I); // R6
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R11

endmodule

// File: tb/mesi_coh_ctrl_test.sv
`timescale 1ns/1ps
module mesi_coh_ctrl_test;

  localparam int ADDR_W   = 32;
  localparam int LINE_B   = 64;
  localparam int UL_B     = 32;
  localparam int OFF_W    = 6;
  localparam int LAW      = ADDR_W - OFF_W;
  localparam int NMSG     = LINE_B / UL_B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [2:0]     req_cmd = '0;
  logic           req_hit = 1'b0;
  logic [1:0]     req_state = '0;
  logic [1:0]     req_victim_state = '0;
  logic [LAW-1:0] req_line = '0;
  logic [LAW-1:0] req_victim_line = '0;
  logic           bus_valid;
  logic           bus_ready;
  logic [1:0]     bus_op;
  logic [LAW-1:0] bus_line;
  logic [1:0]     bus_snoop_res;
  logic           snp_resp_valid;
  logic [1:0]     snp_resp;
  logic           ul_inv_valid;
  logic [ADDR_W-1:0] ul_inv_addr;
  logic           done;
  logic [1:0]     done_state;
  logic           done_err;
  logic           lru_inv;

  mesi_coh_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_hit(req_hit), .req_state(req_state),
    .req_victim_state(req_victim_state), .req_line(req_line),
    .req_victim_line(req_victim_line), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_op(bus_op), .bus_line(bus_line), .bus_snoop_res(bus_snoop_res),
    .snp_resp_valid(snp_resp_valid), .snp_resp(snp_resp), .ul_inv_valid(ul_inv_valid),
    .ul_inv_addr(ul_inv_addr), .done(done), .done_state(done_state),
    .done_err(done_err), .lru_inv(lru_inv)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Scoreboard: kind 0 response, 1 bus op, 2 upper-level message, 3 completion
  int          exp_k[$];
  logic [63:0] exp_d[$];
  string       exp_t[$];

  task automatic chk(input bit ok, input string tg, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tg, act, exp);
    end
  endtask

  function automatic void push_ev(input int k, input logic [63:0] d, input string t);
    exp_k.push_back(k);
    exp_d.push_back(d);
    exp_t.push_back(t);
  endfunction

  // Bus model: low two line-address bits pick the result
  function automatic logic [1:0] snoop_of(input logic [LAW-1:0] a);
    if (a[1:0] == 2'b01) return 2'd0;
    if (a[1:0] == 2'b10) return 2'd2;
    return 2'd1;
  endfunction

  function automatic void push_ul(input logic [LAW-1:0] a);
    logic [ADDR_W-1:0] base;
    base = {a, {OFF_W{1'b0}}};
    for (int k = 0; k < NMSG; k++)
      push_ev(2, 64'(base + ADDR_W'(k * UL_B)), "R8");
  endfunction

  function automatic void expect_access(input logic [2:0] c, input logic h, input logic [1:0] s,
                                        input logic [1:0] vs, input logic [LAW-1:0] a,
                                        input logic [LAW-1:0] va, input string tg);
    bit         live;
    logic [1:0] fin;
    bit         err;
    bit         lru;
    live = h && (s != 2'd0);
    fin  = s;
    err  = 1'b0;
    lru  = 1'b0;
    if (c >= 3'd2 && c <= 3'd5) begin
      if (!live) push_ev(0, 64'(2'd0), tg);
      else if (c == 3'd2) begin
        if (s == 2'd3) begin push_ev(0, 64'(2'd2), tg); push_ev(1, 64'({2'd1, a}), tg); end
        else push_ev(0, 64'(2'd1), tg);
        fin = 2'd1;
      end else if (c == 3'd3) begin
        if (s == 2'd1) push_ev(0, 64'(2'd1), tg);
        else begin push_ev(0, 64'(2'd0), tg); err = 1'b1; end
      end else if (c == 3'd4) begin
        if (s == 2'd1) begin push_ev(0, 64'(2'd1), tg); push_ul(a); fin = 2'd0; lru = 1'b1; end
        else begin push_ev(0, 64'(2'd0), tg); err = 1'b1; end
      end else begin
        if (s == 2'd3) begin push_ev(0, 64'(2'd2), tg); push_ev(1, 64'({2'd1, a}), tg); end
        else push_ev(0, 64'(2'd1), tg);
        push_ul(a);
        fin = 2'd0;
        lru = 1'b1;
      end
    end else if (c <= 3'd1) begin
      if (!h && vs == 2'd3) begin
        push_ev(1, 64'({2'd1, va}), tg);
        push_ul(va);
      end
      if (c == 3'd0) begin
        if (!live) begin
          push_ev(1, 64'({2'd0, a}), tg);
          fin = (snoop_of(a) == 2'd0) ? 2'd2 : 2'd1;
        end
      end else begin
        fin = 2'd3;
        if (!live) push_ev(1, 64'({2'd3, a}), tg);
        else if (s == 2'd1) push_ev(1, 64'({2'd2, a}), tg);
      end
    end else begin
      err = 1'b1;
    end
    push_ev(3, 64'({lru, err, fin}), tg);
  endfunction

  task automatic access(input logic [2:0] c, input logic h, input logic [1:0] s, input logic [1:0] vs,
                        input logic [LAW-1:0] a, input logic [LAW-1:0] va, input string tg);
    expect_access(c, h, s, vs, a, va, tg);
    req_cmd = c; req_hit = h; req_state = s; req_victim_state = vs;
    req_line = a; req_victim_line = va; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_cmd = 3'd7; req_state = 2'd3; req_line = '1;
    while (exp_k.size() != 0) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", 64'(req_ready), 64'(1));
    @(posedge clk); #1;
  endtask

  // Bus responder with a rotating ready delay of 0..2 cycles
  int wait_cnt = 0;
  int dly = 0;
  initial begin
    bus_ready = 1'b0;
    bus_snoop_res = 2'd3;
    forever begin
      @(posedge clk); #1;
      if (bus_ready) begin
        bus_ready = 1'b0;
        bus_snoop_res = 2'd3;
      end else if (bus_valid) begin
        if (wait_cnt == 0) begin
          bus_ready = 1'b1;
          bus_snoop_res = snoop_of(bus_line);
          dly = (dly + 1) % 3;
          wait_cnt = dly;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  // Monitor: pops the scoreboard as events appear
  int          mon_k;
  logic [63:0] mon_d;
  bit          mon_have;
  bit          hold_pend = 1'b0;
  logic [1:0]  hold_op;
  logic [LAW-1:0] hold_line;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(bus_valid && bus_op == hold_op && bus_line == hold_line, "R10",
            64'({bus_valid, bus_op, bus_line}), 64'({1'b1, hold_op, hold_line}));
      end
      hold_pend = bus_valid && !bus_ready;
      hold_op   = bus_op;
      hold_line = bus_line;
      mon_have = 1'b1;
      mon_k = 0;
      mon_d = '0;
      if (snp_resp_valid)              begin mon_k = 0; mon_d = 64'(snp_resp); end
      else if (bus_valid && bus_ready) begin mon_k = 1; mon_d = 64'({bus_op, bus_line}); end
      else if (ul_inv_valid)           begin mon_k = 2; mon_d = 64'(ul_inv_addr); end
      else if (done)                   begin mon_k = 3; mon_d = 64'({lru_inv, done_err, done_state}); end
      else mon_have = 1'b0;
      if (mon_have) begin
        if (exp_k.size() == 0) begin
          chk(1'b0, "R11 unexpected event", {32'(mon_k), mon_d[31:0]}, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          chk(mon_k == exp_k[0] && mon_d == exp_d[0], exp_t[0],
              {32'(mon_k), mon_d[31:0]}, {32'(exp_k[0]), exp_d[0][31:0]});
          void'(exp_k.pop_front());
          void'(exp_d.pop_front());
          void'(exp_t.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R11: watchdog expired, actual still running expected finished");
    finish_run();
  end

  localparam logic [LAW-1:0] A_NO = 26'h0012341; // NOHIT
  localparam logic [LAW-1:0] A_HM = 26'h0045602; // HITM
  localparam logic [LAW-1:0] A_HT = 26'h0078900; // HIT
  localparam logic [LAW-1:0] A_H3 = 26'h00abc03; // HIT
  localparam logic [LAW-1:0] V_A  = 26'h0300017;
  localparam logic [LAW-1:0] V_B  = 26'h3ffffc8;

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready && !bus_valid && !ul_inv_valid && !snp_resp_valid && !done, "R1",
        64'({req_ready, bus_valid, ul_inv_valid, snp_resp_valid, done}), 64'(5'b10000));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !ul_inv_valid && !snp_resp_valid && !done, "R1",
        64'({req_ready, bus_valid, ul_inv_valid, snp_resp_valid, done}), 64'(5'b10000));
    @(posedge clk); #1;

    // R2: read fills
    access(3'd0, 1'b0, 2'd0, 2'd0, A_NO, V_A, "R2");
    access(3'd0, 1'b1, 2'd0, 2'd3, A_HM, V_A, "R2");
    access(3'd0, 1'b0, 2'd0, 2'd1, A_HT, V_A, "R2");
    access(3'd0, 1'b0, 2'd0, 2'd2, A_H3, V_B, "R2");
    // R3: read hits and writes
    access(3'd0, 1'b1, 2'd3, 2'd0, A_HT, V_A, "R3");
    access(3'd0, 1'b1, 2'd2, 2'd0, A_NO, V_A, "R3");
    access(3'd0, 1'b1, 2'd1, 2'd3, A_HM, V_A, "R3");
    access(3'd1, 1'b1, 2'd2, 2'd0, A_HT, V_A, "R3");
    access(3'd1, 1'b1, 2'd1, 2'd0, A_NO, V_A, "R3");
    access(3'd1, 1'b1, 2'd3, 2'd0, A_H3, V_A, "R3");
    access(3'd1, 1'b0, 2'd0, 2'd1, A_HM, V_A, "R3");
    access(3'd1, 1'b1, 2'd0, 2'd0, A_HT, V_A, "R3");
    // R4: dirty victims
    access(3'd0, 1'b0, 2'd0, 2'd3, A_NO, V_A, "R4");
    access(3'd0, 1'b0, 2'd0, 2'd3, A_HM, V_B, "R4");
    access(3'd1, 1'b0, 2'd0, 2'd3, A_HT, V_B, "R4");
    // R5: snoop read / write on S
    access(3'd2, 1'b1, 2'd3, 2'd0, A_HT, V_A, "R5");
    access(3'd2, 1'b1, 2'd2, 2'd0, A_NO, V_A, "R5");
    access(3'd2, 1'b1, 2'd1, 2'd0, A_HM, V_A, "R5");
    access(3'd3, 1'b1, 2'd1, 2'd0, A_H3, V_A, "R5");
    // R6: snoop moves to I
    access(3'd5, 1'b1, 2'd3, 2'd0, A_HM, V_A, "R6");
    access(3'd5, 1'b1, 2'd2, 2'd0, A_NO, V_A, "R6");
    access(3'd5, 1'b1, 2'd1, 2'd0, A_H3, V_A, "R6");
    access(3'd4, 1'b1, 2'd1, 2'd0, A_HT, V_A, "R6");
    // R7: snoop misses and hits on I
    for (int c = 2; c <= 5; c++) begin
      access(3'(c), 1'b0, 2'd2, 2'd3, A_HT, V_A, "R7");
      access(3'(c), 1'b1, 2'd0, 2'd3, A_HM, V_A, "R7");
    end
    // R9: illegal combinations
    access(3'd3, 1'b1, 2'd3, 2'd0, A_HT, V_A, "R9");
    access(3'd3, 1'b1, 2'd2, 2'd0, A_HT, V_A, "R9");
    access(3'd4, 1'b1, 2'd3, 2'd0, A_NO, V_A, "R9");
    access(3'd4, 1'b1, 2'd2, 2'd0, A_NO, V_A, "R9");
    access(3'd6, 1'b1, 2'd2, 2'd3, A_HM, V_A, "R9");
    access(3'd7, 1'b0, 2'd1, 2'd3, A_HM, V_A, "R9");
    // R10: mixed traffic under varying bus delay
    for (int i = 0; i < 6; i++) begin
      access(3'd0, 1'b0, 2'd0, 2'd3, LAW'(i * 5 + 1), LAW'(i + 64), "R10");
      access(3'd5, 1'b1, 2'd3, 2'd0, LAW'(i * 7 + 2), V_A, "R10");
    end
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule